// File: doc/BRIEF.md
# Punctured Rate-3/4 Convolutional Encoder

This block turns a serial stream of information bits into a forward-error-correction coded stream. Each accepted bit goes through a constraint-length-3 convolutional code with two generators, which gives two coded bits per input. A puncturing stage then deletes some of those bits in a repeating three-input pattern. Every three information bits become four transmitted bits, so the code rate rises from 1/2 to 3/4. When puncturing is disabled, the block emits both coded bits for every input, which gives plain rate 1/2.

The coded bits pass through a small serial FIFO. The FIFO absorbs the uneven production rate (two, one or one bit per input). It drains one bit per clock and raises `out_valid` while it holds data. The input side accepts a bit only when the FIFO has room for two more bits.

A flush request feeds two zero bits through the encoder, using the same puncturing path, so that the encoder ends in the all-zero state. A synchronous clear returns the encoder to a known starting point without a reset.

Top module: `punct_conv_enc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The encoder keeps the two previous input bits p1 (one step back) and p2 (two steps back), both 0 after reset or clear. For input u, the first coded bit is c0 = u^p2 (generator 101) and the second is c1 = u^p1^p2 (generator 111).
- R3: With `punct_en` low, each accepted input emits two bits, c0 first and then c1.
- R4: With `punct_en` high, the inputs form groups of three in a phase sequence. The first input of a group emits c0 then c1, the second emits only c1, and the third emits only c0, so each group gives four output bits.
- R5: The puncture phase advances only on inputs taken while `punct_en` is high. An input taken with `punct_en` low leaves the phase unchanged.
- R6: While the FIFO holds data, `out_valid` is high and one bit leaves per clock, in production order, with no bit lost or repeated. When the FIFO is empty, `out_valid` is low.
- R7: `in_ready` is high only when the FIFO has at least two free slots, no flush is in progress, and `flush` is low. An input is taken on a cycle with `in_valid` and `in_ready` both high.
- R8: A pulse on `flush` encodes two zero bits through the current puncture path. `in_ready` stays low until both zero bits have been encoded. Afterwards the encoder state is all zero.
- R9: On a cycle with `clear` high, the shift register is zeroed, the phase returns to the first position, the FIFO is emptied and any pending flush is cancelled. `out_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of encoder, phase, FIFO and flush |
| punct_en | input | 1 | 1 selects rate 3/4 puncturing, 0 selects rate 1/2 |
| flush | input | 1 | Pulse to encode two zero tail bits |
| in_valid | input | 1 | Information bit on `in_bit` is valid |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Block can take an input this cycle |
| out_valid | output | 1 | `out_bit` carries a coded bit |
| out_bit | output | 1 | Serial coded bit |

## Verification
Several properties are checked on every cycle:
- an input is never taken without room for two bits;
- a flush blocks input on the following cycle;
- a clear empties the output on the following cycle;
- a bypass-mode input leaves the phase unchanged;
- the phase never reaches an illegal value;
- the FIFO drains by exactly one when nothing is pushed.

The coded values themselves can only be shown by the bench's scenarios, which compare every output bit with an independent model. These scenarios cover:
- the generator arithmetic and the exact bit order of each puncture phase;
- the phase continuing across a switch into and out of bypass mode;
- the return to the zero state after a flush or a clear.

// File: rtl/pce_pkg.sv
package pce_pkg;

    // Position inside a three-input puncturing group
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } pphase_t;

    // Encoder memory: the two most recent accepted bits
    typedef struct packed {
        logic prev1;
        logic prev2;
    } enc_state_t;

    localparam int unsigned CONSTRAINT_LEN = 3;
    localparam int unsigned MEM_BITS       = CONSTRAINT_LEN - 1;

endpackage

// File: rtl/pce_conv_core.sv
module pce_conv_core
    import pce_pkg::*;
#(
    parameter logic [CONSTRAINT_LEN-1:0] GEN_A = 3'b101,
    parameter logic [CONSTRAINT_LEN-1:0] GEN_B = 3'b111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                step,
    input  logic                din,
    output logic                c0,
    output logic                c1,
    output logic [MEM_BITS-1:0] state
);

    enc_state_t st_q, st_d;
    logic [CONSTRAINT_LEN-1:0] taps;

    // Tap vector: MSB is the current bit, LSB the oldest stored bit
    always_comb begin
        taps = {din, st_q.prev1, st_q.prev2};
        c0   = ^(taps & GEN_A);
        c1   = ^(taps & GEN_B);
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (step) begin
            st_d.prev2 = st_q.prev1;
            st_d.prev1 = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state = {st_q.prev1, st_q.prev2};

endmodule

// File: rtl/pce_punct_sel.sv
module pce_punct_sel
    import pce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic       punct_en,
    input  logic       c0,
    input  logic       c1,
    output logic [1:0] n_out,
    output logic       b_first,
    output logic       b_second,
    output logic [1:0] phase
);

    typedef struct packed {
        pphase_t ph;
    } sel_state_t;

    sel_state_t s_q, s_d;
    logic [1:0] n_raw;

    always_comb begin
        b_second = c1;
        if (!punct_en) begin
            n_raw   = 2'd2;
            b_first = c0;
        end else begin
            unique case (s_q.ph)
                PH_FIRST: begin
                    n_raw   = 2'd2;
                    b_first = c0;
                end
                PH_SECOND: begin
                    n_raw   = 2'd1;
                    b_first = c1;
                end
                PH_THIRD: begin
                    n_raw   = 2'd1;
                    b_first = c0;
                end
                default: begin
                    n_raw   = 2'd0;
                    b_first = c0;
                end
            endcase
        end
        n_out = step ? n_raw : 2'd0;

        s_d = s_q;
        if (clear) begin
            s_d.ph = PH_FIRST;
        end else if (step && punct_en) begin
            unique case (s_q.ph)
                PH_FIRST:  s_d.ph = PH_SECOND;
                PH_SECOND: s_d.ph = PH_THIRD;
                default:   s_d.ph = PH_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_FIRST};
        else        s_q <= s_d;
    end

    assign phase = s_q.ph;

endmodule

// File: rtl/pce_bit_fifo.sv
module pce_bit_fifo #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [1:0]    push_n,
    input  logic          d_first,
    input  logic          d_second,
    output logic          empty,
    output logic          head,
    output logic [CW-1:0] count
);

    // DEPTH must be a power of two so the pointers wrap naturally
    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [AW-1:0]    rd;
        logic [AW-1:0]    wr;
        logic [CW-1:0]    cnt;
    } fifo_state_t;

    fifo_state_t s_q, s_d;
    logic        pop;
    logic [AW-1:0] wr_next;

    always_comb begin
        pop     = (s_q.cnt != '0);
        wr_next = s_q.wr + AW'(1);
        s_d     = s_q;
        if (clear) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (pop) s_d.rd = s_q.rd + AW'(1);
            if (push_n != 2'd0) begin
                s_d.mem[s_q.wr] = d_first;
                s_d.wr          = wr_next;
            end
            if (push_n == 2'd2) begin
                s_d.mem[wr_next] = d_second;
                s_d.wr           = s_q.wr + AW'(2);
            end
            s_d.cnt = s_q.cnt + CW'(push_n) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign empty = (s_q.cnt == '0);
    assign head  = s_q.mem[s_q.rd];
    assign count = s_q.cnt;

endmodule

// File: rtl/punct_conv_enc.sv
module punct_conv_enc
    import pce_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned FLUSH_LEN  = MEM_BITS,
    parameter logic [CONSTRAINT_LEN-1:0] GEN_A = 3'b101,
    parameter logic [CONSTRAINT_LEN-1:0] GEN_B = 3'b111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic punct_en,
    input  logic flush,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit
);

    localparam int unsigned FW = $clog2(FLUSH_LEN + 1);
    localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        logic [FW-1:0] fcnt;
    } ctl_state_t;

    ctl_state_t c_q, c_d;

    logic          room;
    logic          flushing;
    logic          step_in;
    logic          step_fl;
    logic          step;
    logic          enc_bit;
    logic          c0, c1;
    logic [MEM_BITS-1:0] enc_state;
    logic [1:0]    n_out;
    logic          b_first, b_second;
    logic [1:0]    phase;
    logic          fifo_empty;
    logic [CW-1:0] fifo_count;

    always_comb begin
        room     = (fifo_count <= CW'(FIFO_DEPTH - 2));
        flushing = (c_q.fcnt != '0);
        in_ready = room && !flushing && !flush;
        step_in  = in_valid && in_ready && !clear;
        step_fl  = flushing && room && !clear;
        step     = step_in || step_fl;
        enc_bit  = step_fl ? 1'b0 : in_bit;

        c_d = c_q;
        if (clear) begin
            c_d.fcnt = '0;
        end else if (flush && !flushing) begin
            c_d.fcnt = FW'(FLUSH_LEN);
        end else if (step_fl) begin
            c_d.fcnt = c_q.fcnt - FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    pce_conv_core #(
        .GEN_A (GEN_A),
        .GEN_B (GEN_B)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (step),
        .din   (enc_bit),
        .c0    (c0),
        .c1    (c1),
        .state (enc_state)
    );

    pce_punct_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (step),
        .punct_en (punct_en),
        .c0       (c0),
        .c1       (c1),
        .n_out    (n_out),
        .b_first  (b_first),
        .b_second (b_second),
        .phase    (phase)
    );

    pce_bit_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .push_n   (n_out),
        .d_first  (b_first),
        .d_second (b_second),
        .empty    (fifo_empty),
        .head     (out_bit),
        .count    (fifo_count)
    );

    assign out_valid = !fifo_empty;

endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          flush,
    input logic          punct_en,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          step,
    input logic [1:0]    phase,
    input logic [CW-1:0] fifo_count
);

    // R7: an input is only taken with room for two more bits
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (int'(fifo_count) <= int'(DEPTH) - 2));

    // R8: a flush request blocks the input on the next cycle
    assert_flush_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !clear) |=> !in_ready);

    // R9: a clear leaves no output on the next cycle
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);

    // R5: a bypass-mode input leaves the phase unchanged
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !punct_en && !clear) |=> (phase == $past(phase)));

    // R4: the phase stays within the three-position group
    assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    // R6: with nothing pushed, the FIFO drains by exactly one per cycle
    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !clear && !step) |=> (fifo_count == $past(fifo_count) - CW'(1)));

endmodule

bind punct_conv_enc pce_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .flush      (flush),
    .punct_en   (punct_en),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .step       (step),
    .phase      (phase),
    .fifo_count (fifo_count)
);

// File: tb/punct_conv_enc_test.sv
`timescale 1ns/1ps
module punct_conv_enc_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic punct_en = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready;
    logic out_valid;
    logic out_bit;

    int checks = 0;
    int errors = 0;
    int nbits  = 0;
    logic [31:0] obits = '0;
    string cur_req = "R6";

    // independent reference model
    bit m_s1 = 0, m_s2 = 0;
    int m_ph = 0;
    bit exp_q[$];

    always #2 clk = ~clk;

    punct_conv_enc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .punct_en  (punct_en),
        .flush     (flush),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_enc(input bit u, input bit pen);
        bit c0, c1;
        c0 = u ^ m_s2;
        c1 = u ^ m_s1 ^ m_s2;
        if (!pen) begin
            exp_q.push_back(c0); exp_q.push_back(c1);
        end else begin
            case (m_ph)
                0: begin exp_q.push_back(c0); exp_q.push_back(c1); end
                1: exp_q.push_back(c1);
                default: exp_q.push_back(c0);
            endcase
            m_ph = (m_ph + 1) % 3;
        end
        m_s2 = m_s1;
        m_s1 = u;
    endfunction

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && !clear) begin
            obits = {obits[30:0], out_bit};
            nbits++;
            if (exp_q.size() == 0) begin
                chk(cur_req, 1, 0, "unexpected output bit");
            end else begin
                chk(cur_req, int'(out_bit), int'(exp_q.pop_front()), "output bit");
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input bit b, output bit blocked);
        blocked = 0;
        in_valid = 1'b1;
        in_bit = b;
        while (!in_ready) begin
            blocked = 1;
            tick();
        end
        model_enc(b, punct_en);
        tick();
    endtask

    task automatic stop_input();
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (exp_q.size() == 0 && !out_valid) break;
            tick();
        end
        tick();
    endtask

    task automatic do_clear();
        clear = 1'b1;
        exp_q.delete();
        m_s1 = 0; m_s2 = 0; m_ph = 0;
        tick();
        clear = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1", int'(out_valid), 0, "out_valid after reset");
        chk("R1", int'(in_ready), 1, "in_ready after reset");
    endtask

    task automatic t_gen_vector();
        bit blk;
        cur_req = "R2";
        do_clear();
        punct_en = 1'b0;
        send(1, blk); send(0, blk); send(0, blk);
        stop_input();
        drain();
        chk("R2", int'(obits[5:0]), int'(6'b110111), "generator output for 1,0,0");
    endtask

    task automatic t_bypass();
        bit blk;
        cur_req = "R3";
        punct_en = 1'b0;
        nbits = 0;
        send(1, blk); send(1, blk); send(0, blk); send(1, blk); send(0, blk);
        stop_input();
        drain();
        chk("R3", nbits, 10, "bits for 5 bypass inputs");
    endtask

    task automatic t_punct_groups();
        bit blk;
        cur_req = "R4";
        punct_en = 1'b1;
        nbits = 0;
        send(0, blk); send(1, blk); send(1, blk);
        send(1, blk); send(0, blk); send(0, blk);
        stop_input();
        drain();
        chk("R4", nbits, 8, "bits for 6 punctured inputs");
    endtask

    task automatic t_phase_hold();
        bit blk;
        cur_req = "R5";
        do_clear();
        nbits = 0;
        punct_en = 1'b1; send(1, blk);
        punct_en = 1'b0; send(0, blk); send(1, blk);
        punct_en = 1'b1; send(1, blk); send(1, blk);
        stop_input();
        drain();
        chk("R5", nbits, 8, "bits across bypass switch");
    endtask

    task automatic t_backpressure();
        bit blk, saw;
        cur_req = "R7";
        punct_en = 1'b0;
        nbits = 0;
        saw = 0;
        for (int i = 0; i < 12; i++) begin
            send(bit'(i % 3 == 1), blk);
            saw = saw | blk;
        end
        stop_input();
        drain();
        chk("R7", int'(saw), 1, "in_ready dropped under back-to-back input");
        chk("R6", nbits, 24, "no bit lost under backpressure");
    endtask

    task automatic t_flush();
        bit blk;
        cur_req = "R8";
        punct_en = 1'b1;
        send(1, blk); send(1, blk);
        stop_input();
        flush = 1'b1;
        model_enc(0, 1'b1);
        model_enc(0, 1'b1);
        tick();
        flush = 1'b0;
        chk("R8", int'(in_ready), 0, "in_ready during flush");
        drain();
        chk("R8", int'(in_ready), 1, "in_ready after flush");
        punct_en = 1'b0;
        send(1, blk);
        stop_input();
        drain();
        chk("R8", int'(obits[1:0]), 3, "zero state after flush");
    endtask

    task automatic t_clear();
        bit blk;
        cur_req = "R9";
        punct_en = 1'b0;
        send(1, blk); send(0, blk); send(1, blk); send(1, blk);
        punct_en = 1'b1;
        send(1, blk);
        stop_input();
        do_clear();
        chk("R9", int'(out_valid), 0, "out_valid after clear");
        send(1, blk); send(1, blk); send(1, blk);
        stop_input();
        drain();
        chk("R9", int'(obits[3:0]), int'(4'b1100), "state and phase after clear");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                tick();
                t_reset_state();
                t_gen_vector();
                t_bypass();
                t_punct_groups();
                t_phase_hold();
                t_backpressure();
                t_flush();
                t_clear();
                chk("R6", exp_q.size(), 0, "expected bits left over");
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule